// File: doc/BRIEF.md
# Cross-Domain Soft Reset Sequencer

Software starts a soft reset by writing 1 to a self-clearing control bit in the bus clock domain. The sequencer turns that write into a reset that covers the bus-domain logic and also reaches a second, independent clock domain. In that second domain the reset is held until the device reports that initialization is complete. For the whole sequence a busy output tells the bus target to leave every bus cycle unclaimed. The configuration header registers are kept out of the soft reset. The serial EEPROM reload request and the PHY reset answer only to the hardware bus reset.

The bus-side state machine has three states. `B_IDLE` goes to `B_REQ` when a write of 1 arrives. `B_REQ` raises the crossing request and goes to `B_DRAIN` once the synchronized acknowledge is high. `B_DRAIN` drops the request and goes back to `B_IDLE` once the synchronized acknowledge is low again. The other-domain state machine also has three states. `O_IDLE` goes to `O_RST` when the synchronized request is high. `O_RST` holds the other-domain reset and goes to `O_ACK` when init-done is seen, or back to `O_IDLE` if the request disappears because the bus side was aborted. `O_ACK` drives the acknowledge and goes back to `O_IDLE` when the synchronized request drops. A hardware reset in either domain sends that domain's state machine to its idle state at once.

Top module: `soft_rst_seq`

## Requirements
- R1: The soft-reset bit reads back as 0 at all times (`sr_rd_bit` is 0).
- R2: While idle, a write with `sr_wr_bit`=1 raises `bus_busy` and `bus_core_rst` from the next rising bus clock edge. A write with `sr_wr_bit`=0 starts nothing.
- R3: `cfg_hdr_rst` is high only while the hardware bus reset `bus_rst_n` is low, and a soft reset never raises it.
- R4: During a sequence `oth_core_rst` rises and stays high for as long as `init_done` is low. It is released after `init_done` goes high.
- R5: `bus_busy` stays high for as long as `init_done` has not been seen. It falls only after the acknowledge has returned and dropped again, within 30 bus cycles of `init_done` rising.
- R6: A soft-reset write that arrives while a sequence is running is ignored, so the sequence ends once and no second sequence follows.
- R7: `eeprom_load_req` is high for exactly one bus cycle after the hardware bus reset is released and never because of a soft reset. `phy_rst` is high only while `bus_rst_n` is low.
- R8: A hardware bus reset during a sequence drops `bus_busy` at once. After it is released, the other domain leaves reset without any `init_done`.
- R9: A hardware reset in the other domain forces `oth_core_rst` high. A sequence still running then completes after `init_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Hardware bus reset, active low, asynchronous |
| oth_clk | input | 1 | Clock of the second domain |
| oth_rst_n | input | 1 | Hardware reset of the second domain, active low |
| sr_wr | input | 1 | Write strobe for the soft-reset bit |
| sr_wr_bit | input | 1 | Data written to the soft-reset bit |
| init_done | input | 1 | Device initialization complete, second domain |
| sr_rd_bit | output | 1 | Read value of the soft-reset bit |
| bus_busy | output | 1 | Sequence running; the bus target must not respond |
| bus_core_rst | output | 1 | Reset for bus-domain logic that the soft reset covers |
| cfg_hdr_rst | output | 1 | Reset for the preserved configuration header |
| oth_core_rst | output | 1 | Reset for logic in the second domain |
| eeprom_load_req | output | 1 | One-cycle EEPROM load request after hardware reset |
| phy_rst | output | 1 | PHY reset, driven only by hardware reset |

## Verification
The bench holds `init_done` low for a long time to catch a design that releases the other-domain reset or busy on a timer instead of waiting for init-done. It writes a second time during a sequence, and a design that restarts would show busy again after the first sequence. It aborts with a hardware bus reset while the other domain sits in reset, and a design that ignored the dropped request would leave `oth_core_rst` stuck. It also checks that `cfg_hdr_rst`, `phy_rst` and `eeprom_load_req` never move during a soft reset. A design that tied any of them to the soft pulse would fail that check.

// File: rtl/soft_rst_pkg.sv
package soft_rst_pkg;
    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_REQ   = 2'd1,
        B_DRAIN = 2'd2
    } bus_st_t;

    typedef enum logic [1:0] {
        O_IDLE = 2'd0,
        O_RST  = 2'd1,
        O_ACK  = 2'd2
    } oth_st_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;
    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
    end

    assign q = chain[LAST];
endmodule

// File: rtl/srs_bus_fsm.sv
module srs_bus_fsm
    import soft_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_bit,
    input  logic ack_s,
    output logic req,
    output logic busy
);
    bus_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            B_IDLE:  if (wr && wr_bit) st_nx = B_REQ;
            B_REQ:   if (ack_s)        st_nx = B_DRAIN;
            B_DRAIN: if (!ack_s)       st_nx = B_IDLE;
            default:                   st_nx = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= B_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        req  = (st == B_REQ);
        busy = (st != B_IDLE);
    end

    // R2: an accepted write makes busy visible on the next edge
    a_r2_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr && wr_bit) |=> busy);
    // R6: a write during the request phase does not move the machine
    a_r6_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_s) |=> req);
    // R5: busy is released only with the acknowledge low
    a_r5_release_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ack_s);
endmodule

// File: rtl/srs_oth_fsm.sv
module srs_oth_fsm
    import soft_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic init_done,
    output logic ack,
    output logic soft_rst
);
    oth_st_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            O_IDLE: if (req_s)          st_nx = O_RST;
            O_RST:  if (!req_s)         st_nx = O_IDLE;
                    else if (init_done) st_nx = O_ACK;
            O_ACK:  if (!req_s)         st_nx = O_IDLE;
            default:                    st_nx = O_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= O_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        ack      = (st == O_ACK);
        soft_rst = (st == O_RST);
    end

    // R4: the reset holds while the request stays and init is pending
    a_r4_hold_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && req_s && !init_done) |=> soft_rst);
    // R4: the acknowledge rises only after init-done was seen
    a_r4_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(init_done));
endmodule

// File: rtl/soft_rst_seq.sv
module soft_rst_seq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst_n,
    input  logic oth_clk,
    input  logic oth_rst_n,
    input  logic sr_wr,
    input  logic sr_wr_bit,
    input  logic init_done,
    output logic sr_rd_bit,
    output logic bus_busy,
    output logic bus_core_rst,
    output logic cfg_hdr_rst,
    output logic oth_core_rst,
    output logic eeprom_load_req,
    output logic phy_rst
);
    logic req, req_s, ack, ack_s, oth_soft;
    logic boot_seen;

    srs_bus_fsm u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr(sr_wr), .wr_bit(sr_wr_bit),
        .ack_s(ack_s), .req(req), .busy(bus_busy)
    );

    srs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(oth_clk), .rst_n(oth_rst_n), .d(req), .q(req_s)
    );

    srs_oth_fsm u_oth (
        .clk(oth_clk), .rst_n(oth_rst_n), .req_s(req_s), .init_done(init_done),
        .ack(ack), .soft_rst(oth_soft)
    );

    srs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack), .q(ack_s)
    );

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) boot_seen <= 1'b0;
        else            boot_seen <= 1'b1;
    end

    always_comb begin
        sr_rd_bit       = 1'b0;
        bus_core_rst    = !bus_rst_n || bus_busy;
        cfg_hdr_rst     = !bus_rst_n;
        phy_rst         = !bus_rst_n;
        eeprom_load_req = bus_rst_n && !boot_seen;
        oth_core_rst    = !oth_rst_n || oth_soft;
    end

    // R7: the load request is never seen two cycles in a row
    a_r7_load_single: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        eeprom_load_req |=> !eeprom_load_req);
    // R3: a running sequence leaves the header reset low
    a_r3_header_kept: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        bus_busy |-> !cfg_hdr_rst);
endmodule

// File: tb/soft_rst_seq_tb_top.sv
module soft_rst_seq_tb_top;
    logic bus_clk = 0, oth_clk = 0;
    logic bus_rst_n = 0, oth_rst_n = 0;
    logic sr_wr = 0, sr_wr_bit = 0, init_done = 0;
    logic sr_rd_bit, bus_busy, bus_core_rst, cfg_hdr_rst, oth_core_rst;
    logic eeprom_load_req, phy_rst;
    int n_tests = 0, n_fail = 0;
    logic side_bad = 0;
    logic watch = 0;

    always #5 bus_clk = ~bus_clk;
    always #7 oth_clk = ~oth_clk;

    soft_rst_seq dut_i (.*);

    // flags any soft-reset disturbance of hardware-only outputs
    always @(negedge bus_clk)
        if (watch && (cfg_hdr_rst || phy_rst || eeprom_load_req || sr_rd_bit))
            side_bad <= 1;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic write_bit(input logic b);
        sr_wr = 1; sr_wr_bit = b;
        @(negedge bus_clk);
        sr_wr = 0; sr_wr_bit = 0;
    endtask

    task automatic set_done(input logic v);
        @(negedge oth_clk); init_done = v;
    endtask

    task automatic wait_idle(input int lim, output int took);
        took = 0;
        while (bus_busy && took < lim) begin
            @(negedge bus_clk); took++;
        end
    endtask

    task automatic t_reset_state;
        chk("R3 cfg_hdr_rst in reset", cfg_hdr_rst, 1);
        chk("R7 phy_rst in reset", phy_rst, 1);
        chk("R7 no load req in reset", eeprom_load_req, 0);
        @(negedge bus_clk); bus_rst_n = 1; oth_rst_n = 1;
        #1;
        chk("R7 load req after release", eeprom_load_req, 1);
        cyc(1);
        chk("R7 load req single cycle", eeprom_load_req, 0);
        chk("R3 cfg_hdr_rst released", cfg_hdr_rst, 0);
        chk("R2 idle busy", bus_busy, 0);
        chk("R1 readback", sr_rd_bit, 0);
        cyc(5);
        chk("R4 oth idle", oth_core_rst, 0);
    endtask

    task automatic t_write_zero;
        write_bit(0);
        chk("R2 zero write no busy", bus_busy, 0);
        cyc(10);
        chk("R2 zero write no oth rst", oth_core_rst, 0);
    endtask

    task automatic t_full_seq;
        int took;
        watch = 1;
        sr_wr = 1; sr_wr_bit = 1;
        @(negedge bus_clk);
        sr_wr = 0; sr_wr_bit = 0;
        chk("R2 busy next cycle", bus_busy, 1);
        chk("R2 core rst", bus_core_rst, 1);
        chk("R1 readback during seq", sr_rd_bit, 0);
        cyc(40);
        chk("R4 oth rst held", oth_core_rst, 1);
        chk("R5 busy held", bus_busy, 1);
        write_bit(1);           // R6 ignored write
        set_done(1);
        wait_idle(30, took);
        chk("R5 busy released", bus_busy, 0);
        chk("R4 oth rst released", oth_core_rst, 0);
        set_done(0);
        cyc(20);
        chk("R6 no second sequence", bus_busy, 0);
        chk("R6 oth stays idle", oth_core_rst, 0);
        watch = 0;
        chk("R3 R7 side outputs untouched", side_bad, 0);
    endtask

    task automatic t_bus_abort;
        write_bit(1);
        cyc(20);
        chk("R8 seq running", oth_core_rst, 1);
        bus_rst_n = 0; #1;
        chk("R8 busy dropped", bus_busy, 0);
        chk("R8 header reset by hw", cfg_hdr_rst, 1);
        cyc(2); bus_rst_n = 1;
        cyc(20);
        chk("R8 oth released without done", oth_core_rst, 0);
        chk("R8 busy stays low", bus_busy, 0);
    endtask

    task automatic t_oth_reset;
        int took;
        write_bit(1);
        cyc(15);
        oth_rst_n = 0; #1;
        chk("R9 oth rst forced", oth_core_rst, 1);
        cyc(3); oth_rst_n = 1;
        cyc(15);
        chk("R9 still busy", bus_busy, 1);
        set_done(1);
        wait_idle(30, took);
        chk("R9 seq completes", bus_busy, 0);
        chk("R9 oth released", oth_core_rst, 0);
        set_done(0);
    endtask

    initial begin
        fork
            begin
                cyc(3);
                t_reset_state();
                t_write_zero();
                t_full_seq();
                t_bus_abort();
                t_oth_reset();
            end
            begin
                repeat (100000) @(posedge bus_clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule